// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. Software writes a small control word: a start bit, a reference-enable bit, a 3-bit input selector and a 2-bit conversion-clock selector. The block drives the selector onto the analog multiplexer and presents a trial code to the DAC. On every conversion-clock tick it samples the comparator and resolves one result bit, beginning with the most significant one.

The start bit doubles as the busy indicator. It reads 1 from the moment a start is accepted until the conversion that serves it finishes, so software can poll it. Completion loads the 8-bit result register in one step and raises a sticky completion flag, which only software clears. The conversion clock is the system clock divided by 4, 16 or 64, or one tick per rising edge of a separate slow oscillator input. After each conversion at least two conversion-clock periods pass before the next conversion can begin. A start that arrives during a conversion or during that idle gap is held and served once the gap ends. When the reference-enable bit is 0 the reference is off and the block does no converting.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A control write with the start bit at 1 and the enable bit at 1 makes `run_bit` read 1 from the next cycle. `run_bit` returns to 0 in the same cycle that the completion flag rises, unless a further start is pending. Writing the start bit as 0 has no effect on `run_bit`.
- R2: Completion sets `done_flag`. The flag stays at 1 until a `flag_clr` pulse, which clears it one cycle later. If completion and `flag_clr` fall in the same cycle, the set wins.
- R3: `chan_sel` takes the written 3-bit selector value in the cycle after the write. Code 0 selects input 0 and code 7 selects input 7.
- R4: Rate codes 0, 1 and 2 produce one conversion tick every 4, 16 and 64 system clocks. A write that changes the rate code restarts the period count. A start written together with power-up (or a rate change), with the gap already over, has `run_bit` high for exactly 9·N+1 cycles, where N is the divide ratio.
- R5: Rate code 3 produces one conversion tick per rising edge of `slow_osc`, which is first passed through a two-stage synchroniser.
- R6: While the enable bit is 0 there are no ticks, start writes are ignored, and a conversion in progress is abandoned without changing `result` or `done_flag`. `run_bit` drops within two cycles of the disabling write.
- R7: After a completion, the first trial code of the next conversion appears no earlier than the second tick after the completing tick.
- R8: The first tick after a start presents trial code 0x80. Each later tick keeps the current trial bit if `cmp_in` is 1 (input at or above the trial level) and clears it otherwise, then sets the next lower bit.
- R9: A conversion ends on its eighth comparison tick, which decides bit 0. `result` then equals the resolved code. With an ideal comparator this is the input level.
- R10: `result` keeps its previous value throughout a conversion and changes only on the completing cycle.
- R11: A start accepted while a conversion or the idle gap is in progress is not lost. It begins on the last tick of the gap, and `run_bit` stays 1 across the gap.
- R12: After reset, `run_bit`, `pwr_on`, `chan_sel`, `dac_code`, `result` and `done_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe; all cfg fields are sampled together |
| cfg_run | input | 1 | Start request bit (1 requests a conversion) |
| cfg_pwr | input | 1 | Reference enable (0 turns the reference off) |
| cfg_chan | input | 3 | Analog input selector |
| cfg_rate | input | 2 | Conversion clock: 0 = /4, 1 = /16, 2 = /64, 3 = slow oscillator |
| flag_clr | input | 1 | Clears the completion flag |
| slow_osc | input | 1 | Independent slow oscillator clock, asynchronous |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial level |
| run_bit | output | 1 | Start bit readback; 1 while pending or converting |
| pwr_on | output | 1 | Reference enable to the analog ladder |
| chan_sel | output | 3 | Multiplexer select |
| dac_code | output | 8 | Trial code to the DAC |
| result | output | 8 | Last completed conversion result |
| done_flag | output | 1 | Sticky completion flag |

## Verification
On every cycle the assertions check the local timing rules: no tick while the reference is off, ticks never back to back, the first trial being the MSB, the idle gap, an unserved start staying held, the result register moving only on completion, and the flag being sticky. The exact tick period for each rate code, the bit-by-bit trial sequence for a given input level, the full latency of back-to-back conversions and the recovery after an abandoned conversion all depend on counts taken over many cycles. Only the bench's cycle-accurate model and its scenarios, run against an ideal comparator, can show those.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_GAP  = 2'd2
  } sar_state_e;

  localparam int          RATE_W    = 2;
  localparam logic [1:0]  RATE_SLOW = 2'b11;

endpackage

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs
  import sar_seq_pkg::*;
#(
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_run,
  input  logic              cfg_pwr,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              flag_clr,
  input  logic              fin_i,
  output logic              pwr_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              rate_chg_o,
  output logic              start_o,
  output logic              flag_o
);

  logic              pwr_q;
  logic [RATE_W-1:0] rate_q;
  logic [CHAN_W-1:0] chan_q;
  logic              flag_q;

  // a start is only accepted when the same write leaves the reference on
  assign start_o    = cfg_we && cfg_run && cfg_pwr;
  assign rate_chg_o = cfg_we && (cfg_rate != rate_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q  <= 1'b0;
      rate_q <= '0;
      chan_q <= '0;
    end else if (cfg_we) begin
      pwr_q  <= cfg_pwr;
      rate_q <= cfg_rate;
      chan_q <= cfg_chan;
    end
  end

  // completion has priority over the software clear
  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (fin_i)    flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign pwr_o  = pwr_q;
  assign rate_o = rate_q;
  assign chan_o = chan_q;
  assign flag_o = flag_q;

  p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
    fin_i |=> flag_q)
    else $error("completion did not raise the flag");

  p_flag_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q)
    else $error("flag dropped without a clear");

  p_chan_follow_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (chan_q == $past(cfg_chan)))
    else $error("selector did not follow the write");

endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen
  import sar_seq_pkg::*;
#(
  parameter int DIV0_LOG2   = 2,
  parameter int DIV1_LOG2   = 4,
  parameter int DIV2_LOG2   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              rate_chg_i,
  input  logic              slow_i,
  output logic              tick_o
);

  localparam int CNT_W = DIV2_LOG2;
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'((1 << DIV0_LOG2) - 1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'((1 << DIV1_LOG2) - 1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'((1 << DIV2_LOG2) - 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     lim;
  logic                 wrap;
  logic [SYNC_STAGES:0] sync_q;
  logic                 slow_edge;
  logic                 tick_q;

  always_comb begin
    unique case (rate_i)
      2'b00:   lim = LIM0;
      2'b01:   lim = LIM1;
      default: lim = LIM2;
    endcase
  end

  assign wrap = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst)                             cnt_q <= '0;
    else if (!pwr_i || rate_chg_i || wrap) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + CNT_W'(1);
  end

  // synchroniser plus one edge-detect stage for the slow oscillator
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], slow_i};
  end

  assign slow_edge = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst)                      tick_q <= 1'b0;
    else if (rate_i == RATE_SLOW) tick_q <= pwr_i && slow_edge;
    else                          tick_q <= pwr_i && wrap && !rate_chg_i;
  end

  assign tick_o = tick_q;

  p_quiet_off_r6: assert property (@(posedge clk) disable iff (rst)
    !pwr_i |=> !tick_q)
    else $error("tick while reference is off");

  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q)
    else $error("conversion ticks back to back");

endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_seq_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int GAP_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             fin_o
);

  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam int GAP_W = $clog2(GAP_TICKS + 1);
  localparam logic [IDX_W-1:0] IDX_MSB  = IDX_W'(RES_W - 1);
  localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TICKS - 1);

  sar_state_e       state_q;
  logic [IDX_W-1:0] bit_idx_q;
  logic [RES_W-1:0] trial_q;
  logic [RES_W-1:0] result_q;
  logic [GAP_W-1:0] gap_q;
  logic             pend_q;
  logic [RES_W-1:0] cur_mask;
  logic [RES_W-1:0] kept;
  logic             gap_last;
  logic             in_conv;

  assign cur_mask = {{(RES_W-1){1'b0}}, 1'b1} << bit_idx_q;
  assign kept     = cmp_i ? trial_q : (trial_q & ~cur_mask);
  assign gap_last = (gap_q == GAP_LAST);
  assign in_conv  = (state_q == ST_CONV);
  assign fin_o    = pwr_i && in_conv && tick_i && (bit_idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_idx_q <= '0;
      trial_q   <= '0;
      result_q  <= '0;
      gap_q     <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (!pwr_i) begin
        state_q <= ST_IDLE;
        pend_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (tick_i && pend_q) begin
              state_q   <= ST_CONV;
              bit_idx_q <= IDX_MSB;
              trial_q   <= MSB_MASK;
              pend_q    <= 1'b0;
            end
          end
          ST_CONV: begin
            if (tick_i) begin
              if (bit_idx_q == '0) begin
                result_q <= kept;
                trial_q  <= kept;
                state_q  <= ST_GAP;
                gap_q    <= '0;
              end else begin
                trial_q   <= kept | (cur_mask >> 1);
                bit_idx_q <= bit_idx_q - IDX_W'(1);
              end
            end
          end
          ST_GAP: begin
            if (tick_i) begin
              if (gap_last) begin
                if (pend_q) begin
                  state_q   <= ST_CONV;
                  bit_idx_q <= IDX_MSB;
                  trial_q   <= MSB_MASK;
                  pend_q    <= 1'b0;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                gap_q <= gap_q + GAP_W'(1);
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
      // a request arriving in the same cycle as a start stays pending
      if (start_i) pend_q <= 1'b1;
    end
  end

  assign busy_o   = pend_q || in_conv;
  assign trial_o  = trial_q;
  assign result_o = result_q;

  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    !pwr_i |=> (state_q == ST_IDLE))
    else $error("conversion continued without reference");

  p_msb_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(in_conv) |-> (trial_q == MSB_MASK))
    else $error("conversion did not begin with the top bit");

  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !fin_o |=> $stable(result_q))
    else $error("result moved outside completion");

  p_gap_r7: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_GAP) && !(tick_i && gap_last)) |=> !in_conv)
    else $error("idle gap cut short");

  p_steps_r9: assert property (@(posedge clk) disable iff (rst)
    (pwr_i && in_conv && tick_i && (bit_idx_q != '0)) |=> in_conv)
    else $error("conversion ended before bit 0");

  p_pend_kept_r11: assert property (@(posedge clk) disable iff (rst)
    (pend_q && pwr_i && !(tick_i && (state_q == ST_IDLE))
            && !(tick_i && (state_q == ST_GAP) && gap_last)) |=> pend_q)
    else $error("held start request lost");

  p_run_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (fin_o && !pend_q && !start_i) |=> !busy_o)
    else $error("busy stayed set after completion");

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int CHAN_W      = 3,
  parameter int DIV0_LOG2   = 2,
  parameter int DIV1_LOG2   = 4,
  parameter int DIV2_LOG2   = 6,
  parameter int GAP_TICKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_run,
  input  logic              cfg_pwr,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic [1:0]        cfg_rate,
  input  logic              flag_clr,
  input  logic              slow_osc,
  input  logic              cmp_in,
  output logic              run_bit,
  output logic              pwr_on,
  output logic [CHAN_W-1:0] chan_sel,
  output logic [RES_W-1:0]  dac_code,
  output logic [RES_W-1:0]  result,
  output logic              done_flag
);

  logic              pwr;
  logic [RATE_W-1:0] rate;
  logic              rate_chg;
  logic              start;
  logic              tick;
  logic              fin;

  sar_cfg_regs #(
    .CHAN_W (CHAN_W)
  ) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_run    (cfg_run),
    .cfg_pwr    (cfg_pwr),
    .cfg_chan   (cfg_chan),
    .cfg_rate   (cfg_rate),
    .flag_clr   (flag_clr),
    .fin_i      (fin),
    .pwr_o      (pwr),
    .rate_o     (rate),
    .chan_o     (chan_sel),
    .rate_chg_o (rate_chg),
    .start_o    (start),
    .flag_o     (done_flag)
  );

  sar_tick_gen #(
    .DIV0_LOG2   (DIV0_LOG2),
    .DIV1_LOG2   (DIV1_LOG2),
    .DIV2_LOG2   (DIV2_LOG2),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tick (
    .clk        (clk),
    .rst        (rst),
    .pwr_i      (pwr),
    .rate_i     (rate),
    .rate_chg_i (rate_chg),
    .slow_i     (slow_osc),
    .tick_o     (tick)
  );

  sar_search #(
    .RES_W     (RES_W),
    .GAP_TICKS (GAP_TICKS)
  ) u_search (
    .clk      (clk),
    .rst      (rst),
    .pwr_i    (pwr),
    .tick_i   (tick),
    .start_i  (start),
    .cmp_i    (cmp_in),
    .busy_o   (run_bit),
    .trial_o  (dac_code),
    .result_o (result),
    .fin_o    (fin)
  );

  assign pwr_on = pwr;

endmodule

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/1ps
module test_sar_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_osc = 1'b0;
  logic       cfg_we = 1'b0, cfg_run = 1'b0, cfg_pwr = 1'b0, flag_clr = 1'b0;
  logic [2:0] cfg_chan = '0;
  logic [1:0] cfg_rate = '0;
  logic       cmp_in;
  logic       run_bit, pwr_on, done_flag;
  logic [2:0] chan_sel;
  logic [7:0] dac_code, result;
  logic [7:0] tgt [0:7];

  always #5 clk = ~clk;
  always #200 slow_osc = ~slow_osc;

  // ideal comparator: analog level of the selected input vs trial code
  assign cmp_in = (tgt[chan_sel] >= dac_code);

  sar_seq_ctrl i_sar_seq_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_run(cfg_run), .cfg_pwr(cfg_pwr),
    .cfg_chan(cfg_chan), .cfg_rate(cfg_rate), .flag_clr(flag_clr),
    .slow_osc(slow_osc), .cmp_in(cmp_in), .run_bit(run_bit), .pwr_on(pwr_on),
    .chan_sel(chan_sel), .dac_code(dac_code), .result(result), .done_flag(done_flag)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pwr, m_rate, m_chan, m_cnt, m_tick, m_mode, m_bit, m_code, m_res, m_flag, m_pend, m_gap;
  logic [2:0] m_sy;
  bit model_on = 0;

  always @(posedge clk) begin
    int period, nt, tk, fin, chg, lvl;
    if (rst) begin
      m_pwr = 0; m_rate = 0; m_chan = 0; m_cnt = 0; m_tick = 0; m_mode = 0;
      m_bit = 0; m_code = 0; m_res = 0; m_flag = 0; m_pend = 0; m_gap = 0;
      m_sy = 3'b000;
      model_on = 1;
    end else begin
      period = (m_rate == 0) ? 4 : (m_rate == 1) ? 16 : 64;
      chg = (cfg_we && (int'(cfg_rate) != m_rate)) ? 1 : 0;
      if (m_rate == 3) nt = (m_pwr != 0 && m_sy[1] && !m_sy[2]) ? 1 : 0;
      else             nt = (m_pwr != 0 && chg == 0 && m_cnt == period - 1) ? 1 : 0;
      if (m_pwr == 0 || chg != 0 || m_cnt == period - 1) m_cnt = 0; else m_cnt = m_cnt + 1;
      tk = m_tick;
      fin = 0;
      lvl = int'(tgt[m_chan]);
      if (m_pwr == 0) begin
        m_mode = 0; m_pend = 0;
      end else if (m_mode == 0) begin
        if (tk != 0 && m_pend != 0) begin m_mode = 1; m_bit = 7; m_code = 128; m_pend = 0; end
      end else if (m_mode == 1) begin
        if (tk != 0) begin
          if (!(lvl >= m_code)) m_code = m_code - (1 << m_bit);
          if (m_bit == 0) begin m_res = m_code; fin = 1; m_mode = 2; m_gap = 0; end
          else begin m_bit = m_bit - 1; m_code = m_code + (1 << m_bit); end
        end
      end else begin
        if (tk != 0) begin
          if (m_gap == 1) begin
            if (m_pend != 0) begin m_mode = 1; m_bit = 7; m_code = 128; m_pend = 0; end
            else m_mode = 0;
          end else m_gap = m_gap + 1;
        end
      end
      if (cfg_we && cfg_run && cfg_pwr) m_pend = 1;
      if (fin != 0) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (cfg_we) begin m_pwr = int'(cfg_pwr); m_rate = int'(cfg_rate); m_chan = int'(cfg_chan); end
      m_tick = nt;
      m_sy = {m_sy[1:0], slow_osc};
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R1 run_bit vs model", int'(run_bit), (m_pend != 0 || m_mode == 1) ? 1 : 0);
      chk("R8 dac_code vs model", int'(dac_code), m_code);
      chk("R9 result vs model", int'(result), m_res);
      chk("R2 done_flag vs model", int'(done_flag), m_flag);
      chk("R3 chan_sel vs model", int'(chan_sel), m_chan);
      chk("R6 pwr_on vs model", int'(pwr_on), m_pwr);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input bit run, input bit pwr, input int chan, input int rate);
    @(negedge clk);
    cfg_we = 1'b1; cfg_run = run; cfg_pwr = pwr;
    cfg_chan = 3'(chan); cfg_rate = 2'(rate);
    @(negedge clk);
    cfg_we = 1'b0; cfg_run = 1'b0;
  endtask

  // returns at the first negedge where run_bit is low; counts high negedges
  task automatic run_len(output int len);
    len = 0;
    while (run_bit) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] seen [$];

  initial begin
    int len, k;
    logic [7:0] prev;
    for (int i = 0; i < 8; i++) tgt[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 run_bit after reset", int'(run_bit), 0);
    chk("R12 pwr_on after reset", int'(pwr_on), 0);
    chk("R12 chan_sel after reset", int'(chan_sel), 0);
    chk("R12 dac_code after reset", int'(dac_code), 0);
    chk("R12 result after reset", int'(result), 0);
    chk("R12 done_flag after reset", int'(done_flag), 0);

    // R4 divide-by-4 latency from power-up, R9 result
    tgt[3] = 8'hA5;
    wr(1, 1, 3, 0);
    run_len(len);
    chk("R4 run length /4 (9*4+1)", len, 37);
    chk("R9 result ch3", int'(result), 'hA5);
    chk("R1 run cleared at completion", int'(run_bit), 0);
    chk("R2 flag set at completion", int'(done_flag), 1);
    idle(10);
    chk("R2 flag sticky", int'(done_flag), 1);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R2 flag cleared by software", int'(done_flag), 0);

    // R3 selector, R1 start bit written as 0
    wr(0, 1, 5, 0);
    chk("R3 chan_sel follows write", int'(chan_sel), 5);
    chk("R1 run=0 write has no effect", int'(run_bit), 0);
    idle(20);
    chk("R1 still idle after run=0 write", int'(run_bit), 0);

    // R8 trial sequence for level 0xC0
    tgt[5] = 8'hC0;
    wr(1, 1, 5, 0);
    prev = dac_code;
    seen.delete();
    forever begin
      if (dac_code != prev) seen.push_back(dac_code);
      prev = dac_code;
      if (!run_bit) break;
      @(negedge clk);
    end
    chk("R8 number of trial codes", seen.size(), 9);
    if (seen.size() == 9) begin
      chk("R8 trial 0", int'(seen[0]), 'h80);
      chk("R8 trial 1", int'(seen[1]), 'hC0);
      chk("R8 trial 2", int'(seen[2]), 'hE0);
      chk("R8 trial 3", int'(seen[3]), 'hD0);
      chk("R8 trial 4", int'(seen[4]), 'hC8);
      chk("R8 trial 5", int'(seen[5]), 'hC4);
      chk("R8 trial 6", int'(seen[6]), 'hC2);
      chk("R8 trial 7", int'(seen[7]), 'hC1);
      chk("R8 final code", int'(seen[8]), 'hC0);
    end
    chk("R9 result ch5", int'(result), 'hC0);

    // R4 divide-by-16: rate change restarts the count
    idle(20);
    tgt[1] = 8'hFF;
    wr(1, 1, 1, 1);
    run_len(len);
    chk("R4 run length /16 (9*16+1)", len, 145);
    chk("R9 result ch1 full scale", int'(result), 'hFF);

    // R4 divide-by-64
    idle(40);
    tgt[0] = 8'h00;
    wr(1, 1, 0, 2);
    run_len(len);
    chk("R4 run length /64 (9*64+1)", len, 577);
    chk("R9 result ch0 zero", int'(result), 0);

    // R11 start held during conversion, R10 result hold
    idle(150);
    tgt[2] = 8'h5A;
    wr(1, 1, 2, 0);
    k = 0;
    while (run_bit) begin
      k++;
      if (k == 10) begin cfg_we = 1'b1; cfg_run = 1'b1; cfg_pwr = 1'b1; cfg_chan = 3'd2; cfg_rate = 2'd0; end
      else begin cfg_we = 1'b0; cfg_run = 1'b0; end
      if (k == 20) chk("R10 result held mid-conversion", int'(result), 0);
      if (k == 40) begin
        chk("R11 first result before held start runs", int'(result), 'h5A);
        chk("R11 run stays high in gap", int'(run_bit), 1);
        tgt[2] = 8'h3C;
      end
      if (k == 50) chk("R10 result held in second conversion", int'(result), 'h5A);
      @(negedge clk);
    end
    cfg_we = 1'b0; cfg_run = 1'b0;
    chk("R11 back-to-back run length (19*4+1)", k, 77);
    chk("R11 held start converted", int'(result), 'h3C);

    // R7 start issued in the idle gap: first trial waits for the second gap tick
    wr(1, 1, 2, 0);
    k = 1;
    while (dac_code != 8'h80 && k < 100) begin
      k++;
      @(negedge clk);
    end
    chk("R7 gap delay before first trial", k, 7);
    run_len(len);
    chk("R7 conversion after gap result", int'(result), 'h3C);

    // R5 slow oscillator clock
    idle(20);
    tgt[4] = 8'h6E;
    wr(1, 1, 4, 3);
    run_len(len);
    chk("R5 slow-clock run length in [320,370]", (len >= 320 && len <= 370) ? 1 : 0, 1);
    chk("R5 result ch4", int'(result), 'h6E);

    // R6 power-down abort and ignored start
    idle(200);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    tgt[6] = 8'h11;
    wr(1, 1, 6, 0);
    idle(15);
    wr(0, 0, 6, 0);
    idle(2);
    chk("R6 run cleared by power-down", int'(run_bit), 0);
    chk("R6 result unchanged after abort", int'(result), 'h6E);
    chk("R6 flag unchanged after abort", int'(done_flag), 0);
    chk("R6 reference off", int'(pwr_on), 0);
    wr(1, 0, 6, 0);
    chk("R6 start ignored while off", int'(run_bit), 0);
    prev = dac_code;
    idle(100);
    chk("R6 no trial activity while off", int'(dac_code), int'(prev));
    chk("R6 result still unchanged", int'(result), 'h6E);
    wr(1, 1, 6, 0);
    run_len(len);
    chk("R6 fresh conversion after power-up", len, 37);
    chk("R9 result ch6", int'(result), 'h11);

    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual run still pending after 150000 cycles, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule